// File: doc/BRIEF.md
# IR Receive Bit Accumulator with Length and Data Compare

This block gathers the decoded bit symbols of an infrared remote-control frame into a 64-bit receive buffer that is split into a low and a high 32-bit word. Symbols arrive one per handshake on a valid/ready stream. A 7-bit counter selects the buffer position for each bit and then advances. The block runs two comparisons on what it has collected. The first raises a flag when the collected length reaches a programmed count. The second checks the first 1 to 8 received bits against an expected byte.

An upstream decoder reports receive errors. When that error line is high and the bypass control is low, incoming symbols are consumed but discarded. Four sticky flags report the following events: data received, buffer full, length match and data match. Each flag is cleared by its own write-one strobe. The counter is cleared by an explicit strobe or by a rising edge of the enable. Each clear holds the stream closed for two cycles, and a busy output reports those two cycles.

Back-pressure: `sym_ready` is high only while the enable is high, was also high in the previous cycle, and no clear is in progress. A symbol transfers in a cycle where both `sym_valid` and `sym_ready` are high. The producer must hold its symbol until that cycle. A transferred symbol is always consumed, even when the block then discards it.

Top module: `ir_bit_accum`

## Requirements
- R1: After reset, both data words, the counter, all four flags and `clr_busy` are 0, and `sym_ready` is 0.
- R2: A transferred, non-discarded symbol with counter value c < 64 writes `sym_bit` to `data_lo[c]` when c < 32, or to `data_hi[c-32]` otherwise. The counter becomes c+1 at the same edge.
- R3: `sym_ready` equals `cnt_en` AND (`cnt_en` one cycle earlier) AND NOT `clr_busy`. Without a transfer, the counter and data do not change.
- R4: The counter never exceeds 64. `full_flag` sets when a store brings the counter to 64. A symbol transferred at count 64 leaves the counter and data unchanged and sets `full_flag`.
- R5: With `rx_err`=1 and `err_bypass`=0, a transferred symbol changes neither the counter nor the data. With `err_bypass`=1, the symbol is stored normally.
- R6: A `cnt_clr` strobe, or a 0-to-1 change of `cnt_en`, zeroes the counter at the next edge. `clr_busy` is then 1 for exactly two cycles, and the data words keep their contents. A clear that coincides with a transfer discards that symbol.
- R7: A 0-to-1 change of `cnt_en` clears all four flags. This clear takes priority over any set in the same cycle.
- R8: `data_clr` zeroes both data words at the next edge only while `cnt_en` is 0. While `cnt_en` is 1, it has no effect.
- R9: With `bc_en`=1, a store that makes the counter equal to `bc_len` (0..64) sets `bmatch_flag`.
- R10: The data compare is a one-shot test. After an arm event (reset, `dc_rearm`, or any counter clear), the first cycle with `dc_en`=1 and counter > `dc_sel` tests `data_lo[dc_sel:0]` against `dc_expect[dc_sel:0]` and disarms. Equality sets `cmatch_flag` one edge later. Bits of `dc_expect` above `dc_sel` are ignored.
- R11: `recv_flag` sets on every store.
- R12: Each flag stays set until its write-one strobe is pulsed. A set event in the same cycle as the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Accumulator enable; a rising edge starts a clear |
| cnt_clr | input | 1 | Write-one strobe that clears the counter |
| data_clr | input | 1 | Strobe that zeroes both words while disabled |
| sym_valid | input | 1 | Symbol valid |
| sym_bit | input | 1 | Symbol value (data-0 or data-1) |
| sym_ready | output | 1 | Block can take a symbol |
| rx_err | input | 1 | Receive error indication from the decoder |
| err_bypass | input | 1 | Keep storing while `rx_err` is high |
| bc_en | input | 1 | Length compare enable |
| bc_len | input | 7 | Length compare value, 0..64 |
| dc_en | input | 1 | Data compare enable |
| dc_expect | input | 8 | Expected leading bits |
| dc_sel | input | 3 | Highest compared bit index |
| dc_rearm | input | 1 | Re-arm the data compare |
| w1c_recv | input | 1 | Clear `recv_flag` |
| w1c_full | input | 1 | Clear `full_flag` |
| w1c_bmatch | input | 1 | Clear `bmatch_flag` |
| w1c_cmatch | input | 1 | Clear `cmatch_flag` |
| data_lo | output | 32 | Buffer bits 0..31 |
| data_hi | output | 32 | Buffer bits 32..63 |
| bit_count | output | 7 | Received bit counter |
| recv_flag | output | 1 | Data received (sticky) |
| full_flag | output | 1 | Buffer full (sticky) |
| bmatch_flag | output | 1 | Length match (sticky) |
| cmatch_flag | output | 1 | Data match (sticky) |
| clr_busy | output | 1 | Counter clear in progress |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8-bit compare and a two-cycle clear. With these values the whole 64-bit buffer can be filled in a few hundred cycles, so the low-to-high word crossing at bit 32 and saturation at 64 are both exercised. The same build covers the widest compare select, where all eight expected bits matter, as well as a narrow one, where the upper expected bits must be ignored. The two-cycle clear window is short enough to check cycle by cycle against the stream handshake.

// File: rtl/ir_acc_pkg.sv
package ir_acc_pkg;
  localparam int NUM_FLAGS = 4;

  typedef enum int unsigned {
    FL_RECV   = 0,
    FL_FULL   = 1,
    FL_BMATCH = 2,
    FL_CMATCH = 3
  } flag_idx_e;
endpackage

// File: rtl/ir_acc_clr_seq.sv
// Counter-clear sequencer: detects the enable rising edge, runs the busy
// window and decides when the symbol stream is open.
module ir_acc_clr_seq #(
  parameter int CLR_CYCLES = 2,
  localparam int BW = $clog2(CLR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic cnt_clr,
  output logic start,
  output logic rise,
  output logic busy,
  output logic settled
);
  logic          en_q;
  logic [BW-1:0] busy_cnt;

  assign rise    = cnt_en & ~en_q;
  assign start   = cnt_clr | rise;
  assign busy    = (busy_cnt != '0);
  assign settled = cnt_en & en_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      en_q <= cnt_en;
      if (start)
        busy_cnt <= BW'(CLR_CYCLES);
      else if (busy)
        busy_cnt <= busy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ir_acc_store.sv
// Bit counter and multi-word receive buffer.
module ir_acc_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2,
  localparam int TOTAL    = WORD_W * NUM_WORDS,
  localparam int CNT_W    = $clog2(TOTAL + 1),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             accept,
  input  logic                             bit_in,
  input  logic                             drop,
  input  logic                             clr_cnt,
  input  logic                             wipe,
  output logic [CNT_W-1:0]                 count,
  output logic [CNT_W-1:0]                 next_count,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  output logic                             stored,
  output logic                             stored_last,
  output logic                             overflow_hit
);
  logic             at_max;
  int unsigned      idx;
  int unsigned      cur_word;
  logic [BIT_W-1:0] bit_pos;

  assign at_max       = (count == CNT_W'(TOTAL));
  assign stored       = accept & ~at_max & ~drop & ~clr_cnt;
  assign overflow_hit = accept & at_max & ~clr_cnt;
  assign next_count   = count + 1'b1;
  assign stored_last  = stored & (count == CNT_W'(TOTAL - 1));

  always_comb begin
    idx      = 32'(count);
    cur_word = idx / WORD_W;
    bit_pos  = BIT_W'(idx % WORD_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr_cnt)
      count <= '0;
    else if (stored)
      count <= next_count;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wipe)
        q <= '0;
      else if (stored && cur_word == 32'(w))
        q[bit_pos] <= bit_in;
    end
    assign words[w] = q;
  end
endmodule

// File: rtl/ir_acc_match.sv
// Length compare and one-shot masked data compare.
module ir_acc_match #(
  parameter int WORD_W = 32,
  parameter int CMP_W  = 8,
  parameter int CNT_W  = 7,
  localparam int SEL_W = $clog2(CMP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  next_count,
  input  logic              stored,
  input  logic [WORD_W-1:0] low_word,
  input  logic              bc_en,
  input  logic [CNT_W-1:0]  bc_len,
  input  logic              dc_en,
  input  logic [CMP_W-1:0]  dc_expect,
  input  logic [SEL_W-1:0]  dc_sel,
  input  logic              rearm,
  output logic              bmatch_set,
  output logic              cmatch_set
);
  logic             armed;
  logic             check;
  logic [CMP_W-1:0] mask;
  logic [CMP_W-1:0] diff;

  for (genvar i = 0; i < CMP_W; i++) begin : g_mask
    assign mask[i] = (SEL_W'(i) <= dc_sel);
  end

  assign diff       = (low_word[CMP_W-1:0] ^ dc_expect) & mask;
  assign check      = armed & dc_en & (count > CNT_W'(dc_sel));
  assign cmatch_set = check & (diff == '0);
  assign bmatch_set = stored & bc_en & (next_count == bc_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b1;
    else if (rearm)
      armed <= 1'b1;
    else if (check)
      armed <= 1'b0;
  end
endmodule

// File: rtl/ir_acc_flags.sv
// Sticky event flags: set wins over write-one clear, init wins over both.
module ir_acc_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (init)
        q[i] <= 1'b0;
      else if (set[i])
        q[i] <= 1'b1;
      else if (w1c[i])
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_bit_accum.sv
module ir_bit_accum
  import ir_acc_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CMP_W      = 8,
  parameter int CLR_CYCLES = 2,
  localparam int NUM_WORDS = 2,
  localparam int TOTAL     = WORD_W * NUM_WORDS,
  localparam int CNT_W     = $clog2(TOTAL + 1),
  localparam int SEL_W     = $clog2(CMP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              data_clr,
  input  logic              sym_valid,
  input  logic              sym_bit,
  output logic              sym_ready,
  input  logic              rx_err,
  input  logic              err_bypass,
  input  logic              bc_en,
  input  logic [CNT_W-1:0]  bc_len,
  input  logic              dc_en,
  input  logic [CMP_W-1:0]  dc_expect,
  input  logic [SEL_W-1:0]  dc_sel,
  input  logic              dc_rearm,
  input  logic              w1c_recv,
  input  logic              w1c_full,
  input  logic              w1c_bmatch,
  input  logic              w1c_cmatch,
  output logic [WORD_W-1:0] data_lo,
  output logic [WORD_W-1:0] data_hi,
  output logic [CNT_W-1:0]  bit_count,
  output logic              recv_flag,
  output logic              full_flag,
  output logic              bmatch_flag,
  output logic              cmatch_flag,
  output logic              clr_busy
);
  logic                             clr_start, en_rise, stream_open;
  logic                             accept, drop, wipe;
  logic                             stored, stored_last, overflow_hit;
  logic                             bmatch_set, cmatch_set;
  logic [CNT_W-1:0]                 next_count;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic [NUM_FLAGS-1:0]             flag_set, flag_w1c, flag_q;

  ir_acc_clr_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_clr (cnt_clr),
    .start   (clr_start),
    .rise    (en_rise),
    .busy    (clr_busy),
    .settled (stream_open)
  );

  assign sym_ready = stream_open;
  assign accept    = sym_valid & stream_open;
  assign drop      = rx_err & ~err_bypass;
  assign wipe      = data_clr & ~cnt_en;

  ir_acc_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .bit_in       (sym_bit),
    .drop         (drop),
    .clr_cnt      (clr_start),
    .wipe         (wipe),
    .count        (bit_count),
    .next_count   (next_count),
    .words        (words),
    .stored       (stored),
    .stored_last  (stored_last),
    .overflow_hit (overflow_hit)
  );

  assign data_lo = words[0];
  assign data_hi = words[1];

  ir_acc_match #(.WORD_W(WORD_W), .CMP_W(CMP_W), .CNT_W(CNT_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (bit_count),
    .next_count (next_count),
    .stored     (stored),
    .low_word   (data_lo),
    .bc_en      (bc_en),
    .bc_len     (bc_len),
    .dc_en      (dc_en),
    .dc_expect  (dc_expect),
    .dc_sel     (dc_sel),
    .rearm      (dc_rearm | clr_start),
    .bmatch_set (bmatch_set),
    .cmatch_set (cmatch_set)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FL_RECV]   = stored;
    flag_set[FL_FULL]   = stored_last | overflow_hit;
    flag_set[FL_BMATCH] = bmatch_set;
    flag_set[FL_CMATCH] = cmatch_set;
    flag_w1c            = '0;
    flag_w1c[FL_RECV]   = w1c_recv;
    flag_w1c[FL_FULL]   = w1c_full;
    flag_w1c[FL_BMATCH] = w1c_bmatch;
    flag_w1c[FL_CMATCH] = w1c_cmatch;
  end

  ir_acc_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (en_rise),
    .set   (flag_set),
    .w1c   (flag_w1c),
    .q     (flag_q)
  );

  assign recv_flag   = flag_q[FL_RECV];
  assign full_flag   = flag_q[FL_FULL];
  assign bmatch_flag = flag_q[FL_BMATCH];
  assign cmatch_flag = flag_q[FL_CMATCH];
endmodule

// File: rtl/ir_acc_checker.sv
module ir_acc_checker #(
  parameter int CNT_W  = 7,
  parameter int TOTAL  = 64,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              cnt_clr,
  input logic              data_clr,
  input logic              sym_valid,
  input logic              sym_ready,
  input logic              rx_err,
  input logic              err_bypass,
  input logic              w1c_recv,
  input logic [WORD_W-1:0] data_lo,
  input logic [WORD_W-1:0] data_hi,
  input logic [CNT_W-1:0]  bit_count,
  input logic              recv_flag,
  input logic              full_flag,
  input logic              bmatch_flag,
  input logic              cmatch_flag,
  input logic              clr_busy
);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CNT_W'(TOTAL));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !sym_ready);

  a_r6_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> bit_count == '0);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && sym_ready) && !cnt_clr && $stable(cnt_en) |=> $stable(bit_count));

  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready && rx_err && !err_bypass && !cnt_clr
    |=> $stable(bit_count) && $stable(data_lo) && $stable(data_hi));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready && !(rx_err && !err_bypass) && bit_count < CNT_W'(TOTAL) && !cnt_clr
    |=> bit_count == $past(bit_count) + 1'b1);

  a_r4_full_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready && bit_count == CNT_W'(TOTAL) && !cnt_clr
    |=> full_flag && $stable(bit_count));

  a_r12_recv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    recv_flag && !w1c_recv && !$rose(cnt_en) |=> recv_flag);

  a_r8_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    data_clr && !cnt_en |=> data_lo == '0 && data_hi == '0);

  a_r7_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en) |=> !recv_flag && !full_flag && !bmatch_flag && !cmatch_flag);
endmodule

bind ir_bit_accum ir_acc_checker u_chk (.*);

// File: tb/tb_ir_bit_accum.sv
`timescale 1ns/1ps
module tb_ir_bit_accum;
  localparam logic [63:0] PAT = 64'hA5C3_1E0F_9B27_64D8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cnt_en = 0, cnt_clr = 0, data_clr = 0, sym_valid = 0, sym_bit = 0;
  logic rx_err = 0, err_bypass = 0, bc_en = 0, dc_en = 0, dc_rearm = 0;
  logic [6:0] bc_len = '0;
  logic [7:0] dc_expect = '0;
  logic [2:0] dc_sel = '0;
  logic w1c_recv = 0, w1c_full = 0, w1c_bmatch = 0, w1c_cmatch = 0;
  logic sym_ready, recv_flag, full_flag, bmatch_flag, cmatch_flag, clr_busy;
  logic [31:0] data_lo, data_hi;
  logic [6:0] bit_count;

  ir_bit_accum dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] m_buf;
  int m_cnt, m_busy;
  bit m_en_q, m_armed, m_recv, m_full, m_bm, m_cm;
  bit rise, rdy, acc, clr, tst, hit, s_recv, s_full, s_bm;
  int msk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_buf = '0; m_cnt = 0; m_busy = 0; m_en_q = 0; m_armed = 1;
      m_recv = 0; m_full = 0; m_bm = 0; m_cm = 0;
    end else begin
      chk("R2", "data_lo", data_lo, m_buf[31:0]);
      chk("R2", "data_hi", data_hi, m_buf[63:32]);
      chk("R4", "bit_count", bit_count, m_cnt);
      chk("R6", "clr_busy", clr_busy, m_busy != 0);
      chk("R11", "recv_flag", recv_flag, m_recv);
      chk("R4", "full_flag", full_flag, m_full);
      chk("R9", "bmatch_flag", bmatch_flag, m_bm);
      chk("R10", "cmatch_flag", cmatch_flag, m_cm);
      rise = cnt_en && !m_en_q;
      rdy  = cnt_en && m_en_q && m_busy == 0;
      chk("R3", "sym_ready", sym_ready, rdy);
      acc  = sym_valid && rdy;
      clr  = cnt_clr || rise;
      tst  = m_armed && dc_en && (m_cnt > int'(dc_sel));
      msk  = (1 << (int'(dc_sel) + 1)) - 1;
      hit  = tst && ((int'(m_buf[7:0]) ^ int'(dc_expect)) & msk) == 0;
      s_recv = 0; s_full = 0; s_bm = 0;
      if (clr) begin
        m_cnt = 0; m_busy = 2;
      end else begin
        if (m_busy > 0) m_busy--;
        if (acc) begin
          if (m_cnt == 64) s_full = 1;
          else if (!(rx_err && !err_bypass)) begin
            m_buf[m_cnt] = sym_bit;
            m_cnt++;
            s_recv = 1;
            if (m_cnt == 64) s_full = 1;
            if (bc_en && m_cnt == int'(bc_len)) s_bm = 1;
          end
        end
      end
      if (data_clr && !cnt_en) m_buf = '0;
      if (rise) begin
        m_recv = 0; m_full = 0; m_bm = 0; m_cm = 0;
      end else begin
        m_recv = s_recv || (m_recv && !w1c_recv);
        m_full = s_full || (m_full && !w1c_full);
        m_bm   = s_bm   || (m_bm && !w1c_bmatch);
        m_cm   = hit    || (m_cm && !w1c_cmatch);
      end
      if (clr || dc_rearm) m_armed = 1;
      else if (tst) m_armed = 0;
      m_en_q = cnt_en;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit b);
    @(negedge clk);
    while (!sym_ready) @(negedge clk);
    sym_valid = 1; sym_bit = b;
    @(negedge clk);
    sym_valid = 0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1", "reset data_lo", data_lo, 0);
    chk("R1", "reset data_hi", data_hi, 0);
    chk("R1", "reset count", bit_count, 0);
    chk("R1", "reset flags", {recv_flag, full_flag, bmatch_flag, cmatch_flag}, 0);
    chk("R1", "reset busy/ready", {clr_busy, sym_ready}, 0);
    rst_n = 1;
    tick(2);

    // R6 enable edge starts a two-cycle clear
    cnt_en = 1;
    tick(1);
    chk("R6", "busy cycle 1", {clr_busy, sym_ready}, 2'b10);
    tick(1);
    chk("R6", "busy cycle 2", {clr_busy, sym_ready}, 2'b10);
    tick(1);
    chk("R6", "busy released", {clr_busy, sym_ready}, 2'b01);

    // R2 R9 R10 R11: 40 bits, length match at 37, 4-bit compare
    bc_en = 1; bc_len = 7'd37;
    dc_en = 1; dc_sel = 3'd3; dc_expect = 8'h78;
    for (int i = 0; i < 40; i++) send(PAT[i]);
    tick(2);
    chk("R2", "low word", data_lo, PAT[31:0]);
    chk("R2", "high word bits", data_hi, {24'h0, PAT[39:32]});
    chk("R2", "count 40", bit_count, 40);
    chk("R11", "recv set", recv_flag, 1);
    chk("R9", "length match", bmatch_flag, 1);
    chk("R10", "masked compare hit", cmatch_flag, 1);

    // R12 write-one clears
    w1c_recv = 1; w1c_full = 1; w1c_bmatch = 1; w1c_cmatch = 1;
    tick(1);
    w1c_recv = 0; w1c_full = 0; w1c_bmatch = 0; w1c_cmatch = 0;
    tick(1);
    chk("R12", "flags cleared", {recv_flag, full_flag, bmatch_flag, cmatch_flag}, 0);
    chk("R12", "count kept", bit_count, 40);

    // R10 one-shot: mismatch after rearm, then match after rearm
    dc_sel = 3'd7; dc_expect = ~PAT[7:0];
    dc_rearm = 1; tick(1); dc_rearm = 0;
    tick(3);
    chk("R10", "full-width mismatch", cmatch_flag, 0);
    dc_expect = PAT[7:0];
    tick(2);
    chk("R10", "disarmed after test", cmatch_flag, 0);
    dc_rearm = 1; tick(1); dc_rearm = 0;
    tick(2);
    chk("R10", "full-width match", cmatch_flag, 1);

    // R5 error drop then bypass
    rx_err = 1;
    for (int i = 0; i < 3; i++) send(1'b1);
    tick(1);
    chk("R5", "dropped count", bit_count, 40);
    chk("R5", "dropped data", data_hi, {24'h0, PAT[39:32]});
    err_bypass = 1;
    send(1'b1); send(1'b0); send(1'b1);
    tick(1);
    chk("R5", "bypass count", bit_count, 43);
    chk("R5", "bypass data", data_hi[10:8], 3'b101);
    rx_err = 0; err_bypass = 0;

    // R4 fill to 64, then overflow symbols
    for (int i = 0; i < 21; i++) send(1'b1);
    tick(1);
    chk("R4", "count 64", bit_count, 64);
    chk("R4", "full on last store", full_flag, 1);
    chk("R2", "upper word filled", data_hi, {21'h1FFFFF, 3'b101, PAT[39:32]});
    w1c_full = 1; tick(1); w1c_full = 0;
    tick(1);
    chk("R12", "full cleared", full_flag, 0);
    send(1'b0); send(1'b0);
    tick(1);
    chk("R4", "saturated count", bit_count, 64);
    chk("R4", "overflow sets full", full_flag, 1);
    chk("R4", "overflow data kept", data_hi, {21'h1FFFFF, 3'b101, PAT[39:32]});

    // R6 explicit counter clear keeps data
    cnt_clr = 1; tick(1); cnt_clr = 0;
    chk("R6", "clr busy 1", {clr_busy, sym_ready}, 2'b10);
    chk("R6", "count zeroed", bit_count, 0);
    tick(1);
    chk("R6", "clr busy 2", clr_busy, 1);
    tick(1);
    chk("R6", "clr done", clr_busy, 0);
    chk("R6", "data kept", data_lo, PAT[31:0]);

    // R8 data clear gated by enable
    data_clr = 1; tick(1); data_clr = 0;
    tick(1);
    chk("R8", "ignored while enabled", data_lo, PAT[31:0]);
    cnt_en = 0; tick(1);
    data_clr = 1; tick(1); data_clr = 0;
    tick(1);
    chk("R8", "wiped while disabled", {data_hi, data_lo}, 0);

    // R7 enable edge clears flags
    chk("R7", "flags set before edge", {recv_flag, full_flag}, 2'b11);
    cnt_en = 1;
    tick(2);
    chk("R7", "flags cleared by edge", {recv_flag, full_flag, bmatch_flag, cmatch_flag}, 0);
    tick(4);
    finish_run();
  end
endmodule